// File: doc/BRIEF.md
# Push-Button Interrupt Flag Controller

This block watches four push buttons and four DIP switches and lets a host processor read them through a small register port. The host selects a register with an 8-bit instruction code. A write strobe and a write byte carry stores, and the read byte returns the selected register without a clock delay.

Each button has an active-low interrupt flag. The flag is latched when the button's synchronised level goes from released to pressed. The four flags are combined onto one shared active-low interrupt line. The host clears a flag through a separate clear register, whose bits act as levels. While a clear bit stays at 1, its flag is held idle. Software must write the bit back to 0 before that button can raise the flag again. A button that is still held when its flag is cleared does not raise the line again, because only a new press edge sets a flag.

Top module: `btn_irq_ctrl`

## Requirements
- R1: Reading code 0x21 returns the synchronised button levels in bits 7:4 (bit 4+n is button n, 1 = pressed) and the synchronised DIP levels in bits 3:0. Both pass through two flops, so an input change shows up after the second rising clock edge.
- R2: Reading code 0x23 returns the flag of button n in bit 4+n. Bits 3:0 of this register always read 0.
- R3: A flag is active low: 1 means idle and 0 means pending. A flag goes to 0 on the clock edge after the synchronised level of its button rises from 0 to 1. Pressing the same button again after a release sets the flag again.
- R4: `irq_n_o` is 0 whenever any flag is 0, and 1 when all four flags are 1.
- R5: Writing code 0x22 stores write bits 7:4 as the clear bits. Clear bit 4+n = 1 makes flag n read 1 from the second edge after the write. Reading code 0x22 returns the clear bits in 7:4, with bits 3:0 reading 0.
- R6: A button still held down after its flag has been cleared, and after its clear bit is written back to 0, does not set the flag again. It also does not pull `irq_n_o` low.
- R7: While clear bit 4+n is 1, press edges on button n are ignored. Once the bit has been written back to 0, the next press sets the flag again.
- R8: Flags are independent. Clearing one pending flag leaves the others pending, and `irq_n_o` stays 0 until every pending flag has been cleared.
- R9: After reset all flags read 1, all clear bits read 0 and `irq_n_o` is 1.
- R10: Reading any code other than 0x21, 0x22 or 0x23 returns 0. Writes to any code other than 0x22, including the flag code, change neither the flags nor the clear bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_i | input | 4 | Raw button levels, 1 = pressed |
| dip_i | input | 4 | Raw DIP switch levels |
| instr_i | input | 8 | Register select code |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| irq_n_o | output | 1 | Shared interrupt, active low |

## Verification
The bench presses a button and clears its flag while the button is still held. A design that sets flags on level instead of on edge would raise the line again as soon as the clear bit returns to 0. It also presses a second button while the first is pending and clears them one at a time. A design that releases the line on the first clear, or that clears the wrong bit, shows up there. It presses a button while its clear bit is held, to catch a clear that acts only as a pulse. Finally it writes to the flag code and to unused codes, which would expose loose address decoding or a flag register that can be written.

// File: rtl/btn_irq_pkg.sv
package btn_irq_pkg;
    localparam int unsigned NUM_BTN  = 4;
    localparam int unsigned NUM_DIP  = 4;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned INSTR_W  = 8;
    localparam int unsigned FLAG_LSB = DATA_W - NUM_BTN;

    typedef logic [INSTR_W-1:0] instr_t;
    typedef logic [DATA_W-1:0]  byte_t;
    typedef logic [NUM_BTN-1:0] btn_vec_t;

    localparam instr_t CODE_STATUS = 8'h21;
    localparam instr_t CODE_CLEAR  = 8'h22;
    localparam instr_t CODE_FLAG   = 8'h23;
endpackage

// File: rtl/btn_sync_2ff.sv
module btn_sync_2ff #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = d_i;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.sync;
endmodule

// File: rtl/btn_flag_bank.sv
module btn_flag_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_n_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] flag_n;
    } bank_st_t;

    bank_st_t     st_d, st_q;
    logic [N-1:0] press;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        press     = lvl_i & ~st_q.prev;
        for (int i = 0; i < N; i++) begin
            if (clr_i[i])      st_d.flag_n[i] = 1'b1;
            else if (press[i]) st_d.flag_n[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev   <= '0;
            st_q.flag_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_n_o = st_q.flag_n;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_CLR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[g] |=> st_q.flag_n[g]) else $error("clear ignored"); // R7
        AST_PRESS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (press[g] && !clr_i[g]) |=> !st_q.flag_n[g]) else $error("press lost"); // R3
        AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(st_q.flag_n[g]) |-> $past(press[g])) else $error("set without edge"); // R6
    end
endmodule

// File: rtl/btn_host_port.sv
module btn_host_port
    import btn_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  instr_t   instr_i,
    input  logic     wr_i,
    input  byte_t    wdata_i,
    input  btn_vec_t btn_lvl_i,
    input  logic [NUM_DIP-1:0] dip_lvl_i,
    input  btn_vec_t flag_n_i,
    output btn_vec_t clr_o,
    output byte_t    rdata_o
);
    typedef struct packed {
        btn_vec_t clr;
    } port_st_t;

    port_st_t st_d, st_q;
    byte_t    rd;

    always_comb begin
        st_d = st_q;
        if (wr_i && instr_i == CODE_CLEAR)
            st_d.clr = wdata_i[DATA_W-1:FLAG_LSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd = '0;
        unique case (instr_i)
            CODE_STATUS: rd = {btn_lvl_i, dip_lvl_i};
            CODE_CLEAR:  rd[DATA_W-1:FLAG_LSB] = st_q.clr;
            CODE_FLAG:   rd[DATA_W-1:FLAG_LSB] = flag_n_i;
            default:     rd = '0;
        endcase
    end

    assign clr_o   = st_q.clr;
    assign rdata_o = rd;

    AST_CLR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && instr_i == CODE_CLEAR) |=> (clr_o == $past(wdata_i[DATA_W-1:FLAG_LSB])))
        else $error("clear write lost"); // R5
    AST_CLR_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && instr_i == CODE_CLEAR) |=> $stable(clr_o))
        else $error("clear changed without write"); // R10
endmodule

// File: rtl/btn_irq_ctrl.sv
module btn_irq_ctrl
    import btn_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BTN-1:0]  btn_i,
    input  logic [NUM_DIP-1:0]  dip_i,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic                wr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                irq_n_o
);
    btn_vec_t           btn_s;
    logic [NUM_DIP-1:0] dip_s;
    btn_vec_t           flag_n;
    btn_vec_t           clr;

    btn_sync_2ff #(.WIDTH(NUM_BTN)) u_sync_btn (
        .clk(clk), .rst_n(rst_n), .d_i(btn_i), .q_o(btn_s)
    );

    btn_sync_2ff #(.WIDTH(NUM_DIP)) u_sync_dip (
        .clk(clk), .rst_n(rst_n), .d_i(dip_i), .q_o(dip_s)
    );

    btn_flag_bank #(.N(NUM_BTN)) u_flags (
        .clk(clk), .rst_n(rst_n), .lvl_i(btn_s), .clr_i(clr), .flag_n_o(flag_n)
    );

    btn_host_port u_port (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .wr_i(wr_i),
        .wdata_i(wdata_i), .btn_lvl_i(btn_s), .dip_lvl_i(dip_s),
        .flag_n_i(flag_n), .clr_o(clr), .rdata_o(rdata_o)
    );

    assign irq_n_o = &flag_n;

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n_o) |-> $past(|clr)) else $error("irq released without clear"); // R8
endmodule

// File: tb/btn_irq_ctrl_tb_top.sv
module btn_irq_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] C_STAT = 8'h21, C_CLR = 8'h22, C_FLAG = 8'h23;

    logic       clk = 0, rst_n = 0, wr = 0;
    logic [3:0] btn = 0, dip = 0;
    logic [7:0] instr = 0, wdata = 0, rdata;
    logic       irq_n;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btn_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .btn_i(btn), .dip_i(dip), .instr_i(instr),
        .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] code, output logic [7:0] v);
        instr = code; #1; v = rdata;
    endtask

    task automatic chk_reg(input string req, input logic [7:0] code, input logic [7:0] exp);
        logic [7:0] v;
        rd(code, v);
        chk(req, v, exp);
    endtask

    task automatic wr_reg(input logic [7:0] code, input logic [7:0] d);
        @(negedge clk); instr = code; wdata = d; wr = 1;
        @(negedge clk); wr = 0; wdata = 0;
    endtask

    task automatic do_reset();
        btn = 0; dip = 0; wr = 0; instr = 0;
        rst_n = 0; tick(2); rst_n = 1; tick(1);
    endtask

    task automatic t_reset();
        do_reset();
        chk_reg("R9 flags", C_FLAG, 8'hF0);
        chk_reg("R9 clear", C_CLR, 8'h00);
        chk("R9 irq", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_status();
        do_reset();
        @(negedge clk); btn = 4'b1010; dip = 4'b0110;
        tick(1);
        chk_reg("R1 latency", C_STAT, 8'h00);
        tick(1);
        chk_reg("R1 status", C_STAT, 8'hA6);
        @(negedge clk); btn = 0; dip = 4'b1001;
        tick(2);
        chk_reg("R1 status2", C_STAT, 8'h09);
    endtask

    task automatic t_single();
        do_reset();
        @(negedge clk); btn[2] = 1; tick(3);
        chk_reg("R3 R2 flag set", C_FLAG, 8'hB0);
        chk("R4 irq low", {7'd0, irq_n}, 8'h00);
        wr_reg(C_CLR, 8'h40); tick(1);
        chk_reg("R5 clear readback", C_CLR, 8'h40);
        chk_reg("R5 flag cleared", C_FLAG, 8'hF0);
        chk("R4 irq high", {7'd0, irq_n}, 8'h01);
        wr_reg(C_CLR, 8'h00); tick(4);
        chk_reg("R6 held no reraise", C_FLAG, 8'hF0);
        chk("R6 irq high", {7'd0, irq_n}, 8'h01);
        @(negedge clk); btn[2] = 0; tick(3);
        btn[2] = 1; tick(4);
        chk_reg("R3 repress", C_FLAG, 8'hB0);
    endtask

    task automatic t_two();
        do_reset();
        @(negedge clk); btn[0] = 1; tick(4);
        chk_reg("R8 first", C_FLAG, 8'hE0);
        btn[3] = 1; tick(4);
        chk_reg("R8 both", C_FLAG, 8'h60);
        wr_reg(C_CLR, 8'h10); wr_reg(C_CLR, 8'h00); tick(1);
        chk_reg("R8 one left", C_FLAG, 8'h70);
        chk("R8 irq still low", {7'd0, irq_n}, 8'h00);
        wr_reg(C_CLR, 8'h80); wr_reg(C_CLR, 8'h00); tick(1);
        chk_reg("R8 all clear", C_FLAG, 8'hF0);
        chk("R8 irq high", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_mask();
        do_reset();
        wr_reg(C_CLR, 8'h20);
        @(negedge clk); btn[1] = 1; tick(4);
        chk_reg("R7 masked", C_FLAG, 8'hF0);
        chk("R7 irq", {7'd0, irq_n}, 8'h01);
        btn[1] = 0; tick(3);
        wr_reg(C_CLR, 8'h00);
        @(negedge clk); btn[1] = 1; tick(4);
        chk_reg("R7 unmasked", C_FLAG, 8'hD0);
    endtask

    task automatic t_other();
        do_reset();
        wr_reg(C_STAT, 8'hF0); wr_reg(8'h55, 8'hF0); tick(1);
        chk_reg("R10 clear untouched", C_CLR, 8'h00);
        @(negedge clk); btn[0] = 1; tick(4);
        wr_reg(C_FLAG, 8'hF0); tick(1);
        chk_reg("R10 flag not writable", C_FLAG, 8'hE0);
        chk_reg("R10 unused code", 8'h00, 8'h00);
        chk_reg("R10 unused code2", 8'h24, 8'h00);
    endtask

    initial begin
        t_reset();
        t_status();
        t_single();
        t_two();
        t_mask();
        t_other();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule